// File: doc/BRIEF.md
# AUX Request Command Packer

This block turns one AUX channel request into the byte stream that a link engine's command FIFO expects. A request carries a 20-bit target address, a direction, a byte count and, for writes, payload bytes pulled one per cycle from a source. The block emits a four-byte header and then the payload as FIFO pushes. The first push also restarts the FIFO write pointer. It then raises a one-cycle start pulse together with the transaction-control flags.

While the link engine runs the transaction, the block reports busy and ignores new requests. When the engine signals completion of a read, the block pops reply entries. The first entry is thrown away. Each entry after that carries a data byte and an 8-bit position tag. A byte is forwarded only if its tag matches the position the block expects, and the first mismatch ends the transfer. The block then reports how many bytes were good.

Requests with a zero byte count are acknowledged at once and produce no traffic. Writes whose header plus payload would not fit in the usable command space are refused.

Top module: `auxreq_packer`

## Requirements
- R1: The first pushed byte is {3'b000, read flag, address[19:16]}: the read flag is bit 4 and the address nibble is bits 3:0. The pointer-restart output is high with that push only.
- R2: The second pushed byte is address[15:8] and the third is address[7:0].
- R3: The fourth pushed byte is the requested byte count minus one.
- R4: On a write, the header is followed by exactly the requested number of payload bytes, in the order the source supplies them. On a read, only the four header bytes are pushed.
- R5: A write whose byte count exceeds 124 raises the reject pulse in the cycle after it is accepted. It pushes nothing and raises no start pulse. A read of any count from 1 to 255 is accepted.
- R6: A request with a byte count of zero raises the zero-count acknowledge pulse in the cycle after it is accepted. It pushes nothing and raises no start pulse.
- R7: The start pulse lasts one cycle and follows the last push. The I2C flag is passed through with it. The suppress-address and suppress-stop flags are passed through only when the I2C flag is set, and are 0 otherwise.
- R8: busy is high from the start-pulse cycle up to the cycle in which link completion is taken. It is low in the cycle after that. A request presented while the block is not idle is ignored.
- R9: After a read completes, the first popped reply entry is discarded. Each later entry whose tag equals its zero-based position is forwarded on the output data port with out_valid.
- R10: Read-back stops at the first entry whose tag differs from its position, or after the requested count. rx_done then pulses for one cycle with rx_count equal to the number of bytes forwarded.
- R11: After reset, the block pushes nothing, pops nothing and raises no pulse, and busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; taken only when idle |
| req_addr | input | 20 | Target address |
| req_read | input | 1 | 1 = read, 0 = write |
| req_len | input | 8 | Byte count |
| req_i2c | input | 1 | I2C-over-AUX mode |
| req_no_addr | input | 1 | Suppress address phase (I2C mode only) |
| req_no_stop | input | 1 | Suppress stop (I2C mode only) |
| pay_data | input | 8 | Current write payload byte |
| pay_take | output | 1 | Payload byte consumed this cycle |
| push_en | output | 1 | Command FIFO push |
| push_data | output | 8 | Byte pushed |
| push_idx_rst | output | 1 | Restart the FIFO write pointer with this push |
| go | output | 1 | Start pulse to the link engine |
| ctl_i2c | output | 1 | I2C mode flag, valid with go |
| ctl_no_addr | output | 1 | Suppress-address flag, valid with go |
| ctl_no_stop | output | 1 | Suppress-stop flag, valid with go |
| busy | output | 1 | Transaction in flight |
| link_done | input | 1 | Link engine finished the transaction |
| rd_pop | output | 1 | Pop a reply entry |
| rd_data | input | 8 | Reply entry data byte |
| rd_idx | input | 8 | Reply entry position tag |
| out_valid | output | 1 | Good read byte on out_data |
| out_data | output | 8 | Read byte |
| rx_done | output | 1 | Read-back finished pulse |
| rx_count | output | 8 | Good bytes in the finished read-back |
| zero_ack | output | 1 | Zero-count request acknowledged |
| reject | output | 1 | Oversize write refused |

## Verification
The assertions assume the following about the surroundings:
- The payload source holds a valid byte whenever the block is in its payload phase.
- The reply source always has an entry at its head while the block pops.
- link_done arrives only while busy.

The bench keeps to these assumptions. Its payload and reply models are arrays indexed by pointers that advance on pay_take and rd_pop. It raises link_done only after it has seen the start pulse. Its one out-of-turn stimulus is a zero-count request presented while busy, and that request must be ignored.

// File: rtl/auxp_pkg.sv
package auxp_pkg;
    localparam int ADDR_W    = 20;
    localparam int LEN_W     = 8;
    localparam int HDR_BYTES = 4;

    typedef enum logic [2:0] {
        S_IDLE, S_HDR, S_PAY, S_GO, S_WAIT, S_SKIP, S_CHK
    } state_t;

    typedef struct packed {
        logic i2c;
        logic no_addr;
        logic no_stop;
    } ctl_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              rd;
        logic [LEN_W-1:0]  len;
        ctl_t              ctl;
    } req_t;

    function automatic logic [7:0] hdr_byte(req_t r, logic [1:0] k);
        logic [7:0] b;
        case (k)
            2'd0:    b = {3'b000, r.rd, r.addr[19:16]};
            2'd1:    b = r.addr[15:8];
            2'd2:    b = r.addr[7:0];
            default: b = r.len - 8'd1;
        endcase
        return b;
    endfunction
endpackage

// File: rtl/auxp_hdr_enc.sv
module auxp_hdr_enc
    import auxp_pkg::*;
(
    input  req_t       req,
    input  logic [1:0] sel,
    output logic [7:0] byte_o
);
    always_comb byte_o = hdr_byte(req, sel);
endmodule

// File: rtl/auxp_rdchk.sv
module auxp_rdchk
    import auxp_pkg::*;
#(
    parameter int W = LEN_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] len,
    input  logic [7:0]   tag,
    output logic         match,
    output logic         last,
    output logic [W-1:0] pos
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            pos <= '0;
        else if (en && match)
            pos <= pos + 1'b1;
    end

    always_comb begin
        match = ({{(W > 8 ? W-8 : 0){1'b0}}, tag} == pos);
        last  = (pos == len - 1'b1);
    end
endmodule

// File: rtl/auxreq_packer.sv
module auxreq_packer
    import auxp_pkg::*;
#(
    parameter int FIFO_DEPTH = 144,
    parameter int CMD_LIMIT  = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_read,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_i2c,
    input  logic              req_no_addr,
    input  logic              req_no_stop,
    input  logic [7:0]        pay_data,
    output logic              pay_take,
    output logic              push_en,
    output logic [7:0]        push_data,
    output logic              push_idx_rst,
    output logic              go,
    output logic              ctl_i2c,
    output logic              ctl_no_addr,
    output logic              ctl_no_stop,
    output logic              busy,
    input  logic              link_done,
    output logic              rd_pop,
    input  logic [7:0]        rd_data,
    input  logic [7:0]        rd_idx,
    output logic              out_valid,
    output logic [7:0]        out_data,
    output logic              rx_done,
    output logic [LEN_W-1:0]  rx_count,
    output logic              zero_ack,
    output logic              reject
);
    localparam int SPACE   = (CMD_LIMIT < FIFO_DEPTH) ? CMD_LIMIT : FIFO_DEPTH;
    localparam int MAX_PAY = SPACE - HDR_BYTES;

    state_t             state;
    req_t               req_q;
    logic [LEN_W-1:0]   cnt;
    logic               zero_q, rej_q, rxd_q;
    logic [LEN_W-1:0]   rxc_q;
    logic [7:0]         hdr_b;
    logic               chk_match, chk_last;
    logic [LEN_W-1:0]   chk_pos;
    logic               take;

    assign take = req_valid && (state == S_IDLE);

    auxp_hdr_enc u_hdr (
        .req    (req_q),
        .sel    (cnt[1:0]),
        .byte_o (hdr_b)
    );

    auxp_rdchk #(.W(LEN_W)) u_chk (
        .clk   (clk),
        .rst   (rst),
        .clr   (state == S_SKIP),
        .en    (state == S_CHK),
        .len   (req_q.len),
        .tag   (rd_idx),
        .match (chk_match),
        .last  (chk_last),
        .pos   (chk_pos)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            req_q  <= '0;
            cnt    <= '0;
            zero_q <= 1'b0;
            rej_q  <= 1'b0;
            rxd_q  <= 1'b0;
            rxc_q  <= '0;
        end else begin
            zero_q <= 1'b0;
            rej_q  <= 1'b0;
            rxd_q  <= 1'b0;
            case (state)
                S_IDLE: if (take) begin
                    if (req_len == '0)
                        zero_q <= 1'b1;
                    else if (!req_read && (int'(req_len) > MAX_PAY))
                        rej_q <= 1'b1;
                    else begin
                        req_q.addr        <= req_addr;
                        req_q.rd          <= req_read;
                        req_q.len         <= req_len;
                        req_q.ctl.i2c     <= req_i2c;
                        req_q.ctl.no_addr <= req_i2c & req_no_addr;
                        req_q.ctl.no_stop <= req_i2c & req_no_stop;
                        cnt               <= '0;
                        state             <= S_HDR;
                    end
                end
                S_HDR: begin
                    if (cnt == LEN_W'(HDR_BYTES - 1)) begin
                        cnt   <= '0;
                        state <= req_q.rd ? S_GO : S_PAY;
                    end else
                        cnt <= cnt + 1'b1;
                end
                S_PAY: begin
                    if (cnt == req_q.len - 1'b1)
                        state <= S_GO;
                    cnt <= cnt + 1'b1;
                end
                S_GO:   state <= S_WAIT;
                S_WAIT: if (link_done) state <= req_q.rd ? S_SKIP : S_IDLE;
                S_SKIP: state <= S_CHK;
                S_CHK: begin
                    if (!chk_match) begin
                        rxd_q <= 1'b1;
                        rxc_q <= chk_pos;
                        state <= S_IDLE;
                    end else if (chk_last) begin
                        rxd_q <= 1'b1;
                        rxc_q <= req_q.len;
                        state <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        push_en      = (state == S_HDR) || (state == S_PAY);
        push_data    = (state == S_HDR) ? hdr_b : pay_data;
        push_idx_rst = (state == S_HDR) && (cnt == '0);
        pay_take     = (state == S_PAY);
        go           = (state == S_GO);
        ctl_i2c      = go & req_q.ctl.i2c;
        ctl_no_addr  = go & req_q.ctl.no_addr;
        ctl_no_stop  = go & req_q.ctl.no_stop;
        busy         = (state == S_GO) || (state == S_WAIT);
        rd_pop       = (state == S_SKIP) || (state == S_CHK);
        out_valid    = (state == S_CHK) && chk_match;
        out_data     = rd_data;
        rx_done      = rxd_q;
        rx_count     = rxc_q;
        zero_ack     = zero_q;
        reject       = rej_q;
    end
endmodule

// File: rtl/auxp_checker.sv
module auxp_checker #(
    parameter int CMD_LIMIT = 128
) (
    input logic clk,
    input logic rst,
    input logic push_en,
    input logic push_idx_rst,
    input logic go,
    input logic ctl_i2c,
    input logic ctl_no_addr,
    input logic ctl_no_stop,
    input logic busy,
    input logic rd_pop,
    input logic out_valid,
    input logic rx_done,
    input logic zero_ack,
    input logic reject
);
    logic [15:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst)
            run_cnt <= '0;
        else if (push_en)
            run_cnt <= push_idx_rst ? 16'd1 : run_cnt + 16'd1;
    end

    assert_restart_with_push_R1: assert property (@(posedge clk) disable iff (rst)
        push_idx_rst |-> push_en);

    assert_cmd_space_R4: assert property (@(posedge clk) disable iff (rst)
        (push_en && !push_idx_rst) |-> (int'(run_cnt) + 1 <= CMD_LIMIT));

    assert_reject_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        reject |-> (!push_en && !go && !zero_ack));

    assert_zero_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        zero_ack |-> (!push_en && !go));

    assert_go_single_R7: assert property (@(posedge clk) disable iff (rst)
        go |=> !go);

    assert_native_flags_R7: assert property (@(posedge clk) disable iff (rst)
        (go && !ctl_i2c) |-> (!ctl_no_addr && !ctl_no_stop));

    assert_go_busy_R8: assert property (@(posedge clk) disable iff (rst)
        go |-> busy);

    assert_no_push_busy_R8: assert property (@(posedge clk) disable iff (rst)
        busy |-> (!push_en && !rd_pop));

    assert_out_on_pop_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> rd_pop);

    assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
        rx_done |=> !rx_done);
endmodule

bind auxreq_packer auxp_checker #(.CMD_LIMIT(CMD_LIMIT)) u_auxp_chk (
    .clk          (clk),
    .rst          (rst),
    .push_en      (push_en),
    .push_idx_rst (push_idx_rst),
    .go           (go),
    .ctl_i2c      (ctl_i2c),
    .ctl_no_addr  (ctl_no_addr),
    .ctl_no_stop  (ctl_no_stop),
    .busy         (busy),
    .rd_pop       (rd_pop),
    .out_valid    (out_valid),
    .rx_done      (rx_done),
    .zero_ack     (zero_ack),
    .reject       (reject)
);

// File: tb/sim_auxreq_packer.sv
module sim_auxreq_packer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [19:0] req_addr = '0;
    logic        req_read = 1'b0;
    logic [7:0]  req_len = '0;
    logic        req_i2c = 1'b0, req_no_addr = 1'b0, req_no_stop = 1'b0;
    logic [7:0]  pay_data;
    logic        pay_take, push_en, push_idx_rst, go;
    logic [7:0]  push_data;
    logic        ctl_i2c, ctl_no_addr, ctl_no_stop, busy;
    logic        link_done = 1'b0;
    logic        rd_pop, out_valid, rx_done, zero_ack, reject;
    logic [7:0]  rd_data, rd_idx, out_data, rx_count;

    always #2 clk = ~clk;

    auxreq_packer u0 (.*);

    logic [7:0] pay_mem [0:255];
    logic [7:0] rep_dat [0:300];
    logic [7:0] rep_tag [0:300];
    int pay_ptr = 0, rep_ptr = 0;
    assign pay_data = pay_mem[pay_ptr[7:0]];
    assign rd_data  = rep_dat[rep_ptr];
    assign rd_idx   = rep_tag[rep_ptr];

    always @(posedge clk) begin
        if (pay_take) pay_ptr <= pay_ptr + 1;
        if (rd_pop && rep_ptr < 300) rep_ptr <= rep_ptr + 1;
    end

    logic [8:0] push_q[$];
    logic [7:0] out_q[$];
    int go_cnt = 0, za_cnt = 0, rj_cnt = 0, rxd_cnt = 0;
    logic [2:0] go_flags;
    logic [7:0] rx_seen;

    always @(negedge clk) begin
        if (push_en)   push_q.push_back({push_idx_rst, push_data});
        if (go)        begin go_cnt++; go_flags = {ctl_i2c, ctl_no_addr, ctl_no_stop}; end
        if (zero_ack)  za_cnt++;
        if (reject)    rj_cnt++;
        if (out_valid) out_q.push_back(out_data);
        if (rx_done)   begin rxd_cnt++; rx_seen = rx_count; end
    end

    int checks = 0, fails = 0;
    bit ended = 0;

    task automatic chk(string tag, bit ok, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
        finish_run();
    end

    function automatic logic [7:0] exp_hdr(logic [19:0] a, logic r, logic [7:0] n, int k);
        case (k)
            0: return {3'b000, r, a[19:16]};
            1: return a[15:8];
            2: return a[7:0];
            default: return n - 8'd1;
        endcase
    endfunction

    task automatic run_txn(logic [19:0] a, logic r, logic [7:0] n, logic i2c, logic na,
                           logic ns, int mis, bit poke);
        int za0, rj0, go0, rxd0, wait_n, exp_cnt;
        bit ok;
        push_q.delete(); out_q.delete();
        for (int i = 0; i < 256; i++) pay_mem[i] = 8'($urandom);
        for (int i = 0; i < 301; i++) begin rep_dat[i] = 8'($urandom); rep_tag[i] = 8'($urandom); end
        for (int i = 0; i < int'(n); i++) rep_tag[i+1] = (i == mis) ? 8'(i + 1) : 8'(i);
        @(posedge clk); #1;
        pay_ptr = 0; rep_ptr = 0;
        za0 = za_cnt; rj0 = rj_cnt; go0 = go_cnt; rxd0 = rxd_cnt;
        req_valid = 1; req_addr = a; req_read = r; req_len = n;
        req_i2c = i2c; req_no_addr = na; req_no_stop = ns;
        @(posedge clk); #1; req_valid = 0;
        if (n == 0 || (!r && n > 124)) begin
            repeat (4) @(negedge clk);
            if (n == 0) chk("R6 zero ack", za_cnt == za0 + 1, za_cnt - za0, 1);
            else        chk("R5 reject", rj_cnt == rj0 + 1, rj_cnt - rj0, 1);
            chk("R5/R6 quiet", push_q.size() == 0 && go_cnt == go0, push_q.size(), 0);
            return;
        end
        wait_n = 0;
        while (go_cnt == go0 && wait_n < 400) begin @(negedge clk); wait_n++; end
        chk("R7 go seen", go_cnt == go0 + 1, go_cnt - go0, 1);
        chk("R4 push count", push_q.size() == (r ? 4 : 4 + int'(n)), push_q.size(), r ? 4 : 4 + int'(n));
        if (push_q.size() >= 4) begin
            chk("R1 byte0", push_q[0] == {1'b1, exp_hdr(a, r, n, 0)}, push_q[0], {1'b1, exp_hdr(a, r, n, 0)});
            ok = 1;
            for (int i = 1; i < push_q.size(); i++) if (push_q[i][8]) ok = 0;
            chk("R1 restart only first", ok, 0, 0);
            chk("R2 byte1", push_q[1][7:0] == exp_hdr(a, r, n, 1), push_q[1][7:0], exp_hdr(a, r, n, 1));
            chk("R2 byte2", push_q[2][7:0] == exp_hdr(a, r, n, 2), push_q[2][7:0], exp_hdr(a, r, n, 2));
            chk("R3 byte3", push_q[3][7:0] == exp_hdr(a, r, n, 3), push_q[3][7:0], exp_hdr(a, r, n, 3));
            if (!r) begin
                ok = 1;
                for (int i = 4; i < push_q.size(); i++) if (push_q[i][7:0] != pay_mem[i-4]) ok = 0;
                chk("R4 payload order", ok, 0, 0);
            end
        end
        chk("R7 flags", go_flags == {i2c, i2c & na, i2c & ns}, go_flags, {i2c, i2c & na, i2c & ns});
        chk("R8 busy at go", busy == 1'b1, busy, 1);
        if (poke) begin
            @(posedge clk); #1;
            req_valid = 1; req_len = 0;
            @(posedge clk); #1; req_valid = 0;
            repeat (3) @(negedge clk);
            chk("R8 ignored while busy", za_cnt == za0 && busy, za_cnt - za0, 0);
        end
        @(posedge clk); #1; link_done = 1;
        @(posedge clk); #1; link_done = 0;
        @(negedge clk);
        chk("R8 busy cleared", busy == 1'b0, busy, 0);
        if (r) begin
            wait_n = 0;
            while (rxd_cnt == rxd0 && wait_n < 600) begin @(negedge clk); wait_n++; end
            exp_cnt = (mis >= 0 && mis < int'(n)) ? mis : int'(n);
            chk("R10 rx done", rxd_cnt == rxd0 + 1, rxd_cnt - rxd0, 1);
            chk("R10 rx count", int'(rx_seen) == exp_cnt, rx_seen, exp_cnt);
            ok = (out_q.size() == exp_cnt);
            for (int i = 0; i < out_q.size() && ok; i++) if (out_q[i] != rep_dat[i+1]) ok = 0;
            chk("R9 read bytes", ok, out_q.size(), exp_cnt);
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd7331));
        for (int i = 0; i < 256; i++) pay_mem[i] = '0;
        for (int i = 0; i < 301; i++) begin rep_dat[i] = '0; rep_tag[i] = '0; end
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        chk("R11 reset idle",
            !push_en && !go && !busy && !rd_pop && !out_valid && !zero_ack && !reject && !rx_done,
            {push_en, go, busy, rd_pop}, 0);
        run_txn(20'hA5C3E, 1'b0, 8'd1,   1'b0, 1'b1, 1'b1, -1, 1'b0);
        run_txn(20'h00050, 1'b0, 8'd124, 1'b1, 1'b1, 1'b0, -1, 1'b1);
        run_txn(20'h12345, 1'b0, 8'd125, 1'b1, 1'b0, 1'b0, -1, 1'b0);
        run_txn(20'hFFFFF, 1'b1, 8'd255, 1'b1, 1'b0, 1'b1, -1, 1'b0);
        run_txn(20'h6789A, 1'b1, 8'd16,  1'b0, 1'b1, 1'b1, 5,  1'b1);
        run_txn(20'h00001, 1'b1, 8'd8,   1'b1, 1'b1, 1'b1, 0,  1'b0);
        run_txn(20'h54321, 1'b1, 8'd0,   1'b0, 1'b0, 1'b0, -1, 1'b0);
        for (int t = 0; t < 40; t++) begin
            logic rr;
            int nn, mm;
            rr = 1'($urandom);
            nn = int'($urandom % 141);
            mm = ($urandom % 3 == 0) ? int'($urandom % 141) : -1;
            run_txn(20'($urandom), rr, 8'(nn), 1'($urandom), 1'($urandom), 1'($urandom),
                    mm, 1'($urandom % 4 == 0));
        end
        finish_run();
    end
endmodule